// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block gives one processor a cycle counter and a single-shot style alarm behind one register address. Reading the address returns a free-running counter that advances by one on every clock. Writing the same address loads a 32-bit compare value. When the low 32 bits of the counter reach that value, a sticky pending flag is set. The interrupt request is that flag gated by an external mask. Software clears the flag with an acknowledge pulse.

The counter is 32 or 64 bits wide, chosen by a parameter. Only its low 32 bits take part in the comparison. A compare value at or behind the count seen at the write fires only once those low bits wrap around to it. Before the first compare write after reset the block never raises a request, even though the cleared compare value equals the cleared counter.

Top module: `interval_timer`

## Requirements
- R1: Reset, asynchronous and active low, sets the counter, the compare value and the pending flag to zero. During reset and right after it, `irq` is 0 and a read returns 0.
- R2: The counter rises by exactly 1 on every clock edge out of reset. While `tmr_rd` is 1, `tmr_rdata` shows the current counter value. While `tmr_rd` is 0, `tmr_rdata` is 0.
- R3: A cycle with `tmr_wr` at 1 loads `tmr_wdata` into the compare register on that clock edge. The compare value stays unchanged in cycles without a write.
- R4: A compare value V is written when the counter is below V. `irq` (unmasked) is then 0 in the cycle the counter reads V and is 1 from the next cycle.
- R5: Once set, the pending flag stays set until it is acknowledged.
- R6: `irq` equals pending AND NOT `irq_mask`. Masking hides the request without clearing the pending flag.
- R7: A cycle with `irq_ack` at 1 clears the pending flag at its clock edge. If a compare match happens in that same cycle, the flag stays set.
- R8: A write to the compare register does not clear a flag that is already pending.
- R9: A compare value equal to or behind the counter at the write does not fire in the following cycles. It fires only after the low 32 bits wrap around to it.
- R10: After reset, no request is raised until the compare register has been written at least once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_rd | input | 1 | Read strobe for the timer address |
| tmr_wr | input | 1 | Write strobe for the timer address (loads compare) |
| tmr_wdata | input | 32 | Compare value to load |
| tmr_rdata | output | CNT_W | Counter value while reading, otherwise 0 |
| irq_mask | input | 1 | 1 hides the request |
| irq_ack | input | 1 | 1 clears the pending flag |
| irq | output | 1 | Interrupt request: pending and not masked |

## Verification
A counter that slips by even one step shows up at once in the read data. It also moves the interrupt edge away from the cycle after the counter reads the compare value, so the bench watches for that edge at exactly one cycle. A compare register or arm state that is lost or stale shows up either as a request during the long quiet windows after a write at or behind the count, or as a request that is missing one cycle after the target. A pending flag that is wrongly cleared or wrongly kept shows up within one cycle of a mask change, a write or an acknowledge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int CMP_W = 32;

    typedef struct packed {
        logic             armed;
        logic [CMP_W-1:0] value;
    } cmp_state_t;

    typedef struct packed {
        logic pend;
    } pend_state_t;

endpackage

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    output logic [CMP_W-1:0] cnt_lo,
    output logic [CNT_W-1:0] rd_data
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    generate
        if (CNT_W != 32 && CNT_W != 64) begin : g_bad_width
            $error("itmr_counter: CNT_W must be 32 or 64");
        end
        if (CNT_W == CMP_W) begin : g_narrow
            assign cnt_lo = cnt_q;
        end else begin : g_wide
            assign cnt_lo = cnt_q[CMP_W-1:0];
        end
    endgenerate

    always_comb begin
        cnt_d   = cnt_q + STEP;
        rd_data = rd_en ? cnt_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + STEP)));   // R2

endmodule

// File: rtl/itmr_compare.sv
module itmr_compare
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_data,
    input  logic [CMP_W-1:0] cnt_lo,
    output logic             match
);

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.value = wr_data;
            st_d.armed = 1'b1;
        end
        match = st_q.armed && (cnt_lo == st_q.value);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.value));   // R3

    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.value == $past(wr_data)));   // R3

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |=> st_q.armed);   // R10

endmodule

// File: rtl/itmr_pending.sv
module itmr_pending
    import itmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic ack,
    input  logic mask,
    output logic pend,
    output logic irq_o
);

    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = match | (st_q.pend & ~ack);
        pend      = st_q.pend;
        irq_o     = st_q.pend & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PEND_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> st_q.pend);   // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !ack) |=> st_q.pend);   // R5

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && ack && !match) |=> !st_q.pend);   // R7

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(match));   // R4

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_rd,
    input  logic             tmr_wr,
    input  logic [31:0]      tmr_wdata,
    output logic [CNT_W-1:0] tmr_rdata,
    input  logic             irq_mask,
    input  logic             irq_ack,
    output logic             irq
);

    logic [CMP_W-1:0] cnt_lo;
    logic             match;
    logic             pend;

    itmr_counter #(.CNT_W(CNT_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (tmr_rd),
        .cnt_lo  (cnt_lo),
        .rd_data (tmr_rdata)
    );

    itmr_compare i_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tmr_wr),
        .wr_data (tmr_wdata),
        .cnt_lo  (cnt_lo),
        .match   (match)
    );

    itmr_pending i_pending (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match),
        .ack   (irq_ack),
        .mask  (irq_mask),
        .pend  (pend),
        .irq_o (irq)
    );

    AST_MASK_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && irq_mask && !irq_ack) |=> pend);   // R6

    AST_WR_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && tmr_wr && !irq_ack) |=> pend);   // R8

endmodule

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;

    localparam int CNT_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd = 1'b1;
    logic             wr = 1'b0;
    logic [31:0]      wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic             mask = 1'b0;
    logic             ack = 1'b0;
    logic             irq;

    interval_timer #(.CNT_W(CNT_W)) i_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_rd    (rd),
        .tmr_wr    (wr),
        .tmr_wdata (wdata),
        .tmr_rdata (rdata),
        .irq_mask  (mask),
        .irq_ack   (ack),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    // Reference cycle count: edges seen since reset release.
    logic [63:0] bc;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bc <= '0;
        else        bc <= bc + 64'd1;
    end

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [63:0] cyc;
        bit          is_rd;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    item_t cur;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, bc);
        end
    endtask

    task automatic push_irq(logic [63:0] cyc, bit val, string req);
        item_t it;
        it.cyc = cyc; it.is_rd = 1'b0; it.exp = {63'd0, val}; it.req = req;
        sb.push_back(it);
    endtask

    task automatic push_rd(logic [63:0] cyc, logic [63:0] val, string req);
        item_t it;
        it.cyc = cyc; it.is_rd = 1'b1; it.exp = val; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wait_bc(logic [63:0] c);
        while (bc != c) @(negedge clk);
    endtask

    task automatic write_cmp(logic [31:0] v);
        wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Monitor: pops scoreboard items when their cycle comes up.
    always @(negedge clk) begin
        #1;
        while (rst_n && sb.size() > 0 && sb[0].cyc <= bc) begin
            cur = sb.pop_front();
            if (cur.cyc != bc)
                check(cur.req, "sample cycle", bc, cur.cyc);
            else if (cur.is_rd)
                check(cur.req, "rdata", rdata, cur.exp);
            else
                check(cur.req, "irq", {63'd0, irq}, cur.exp);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: state during reset
        repeat (3) @(negedge clk);
        #1;
        check("R1", "irq in reset", {63'd0, irq}, 64'd0);
        check("R1", "rdata in reset", rdata, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 quiet before any write; R2 counting and read gating
        for (int t = 1; t <= 40; t++) begin
            push_irq(t, 1'b0, "R10");
            if (t == 3 || t == 17 || t == 30) push_rd(t, t, "R2");
            if (t == 20) push_rd(t, 64'd0, "R2");
        end
        wait_bc(20); rd = 1'b0;
        wait_bc(21); rd = 1'b1;

        // R4 fire timing, R5 sticky
        wait_bc(50);
        push_irq(80, 1'b0, "R4");
        push_irq(81, 1'b1, "R4");
        push_irq(95, 1'b1, "R5");
        write_cmp(32'd80);

        // R6 mask hides without clearing
        wait_bc(100);
        push_irq(100, 1'b0, "R6");
        push_irq(105, 1'b0, "R6");
        push_irq(110, 1'b1, "R6");
        mask = 1'b1;
        wait_bc(110); mask = 1'b0;

        // R8 write keeps pending
        wait_bc(120);
        push_irq(121, 1'b1, "R8");
        push_irq(130, 1'b1, "R8");
        write_cmp(32'd500);

        // R7 acknowledge clears; R3 new compare value takes effect
        wait_bc(140);
        push_irq(141, 1'b0, "R7");
        push_irq(150, 1'b0, "R7");
        push_irq(500, 1'b0, "R3");
        push_irq(501, 1'b1, "R3");
        pulse_ack();
        wait_bc(510);
        push_irq(511, 1'b0, "R7");
        pulse_ack();

        // R9 compare at and behind the count does not fire
        wait_bc(520);
        push_irq(521, 1'b0, "R9");
        push_irq(522, 1'b0, "R9");
        push_irq(600, 1'b0, "R9");
        push_irq(700, 1'b0, "R9");
        write_cmp(32'd520);
        wait_bc(710);
        push_irq(711, 1'b0, "R9");
        push_irq(720, 1'b0, "R9");
        push_irq(800, 1'b0, "R9");
        write_cmp(32'd705);

        // R7 match in the acknowledge cycle wins
        wait_bc(810);
        push_irq(831, 1'b1, "R7");
        push_irq(835, 1'b1, "R7");
        write_cmp(32'd830);
        wait_bc(830);
        pulse_ack();

        // R1 mid-run reset with a request pending
        wait_bc(840);
        rst_n = 1'b0;
        #1;
        check("R1", "irq after reset", {63'd0, irq}, 64'd0);
        check("R1", "rdata after reset", rdata, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 1; t <= 30; t++) begin
            push_irq(t, 1'b0, "R1");
            if (t == 5) push_rd(t, 64'd5, "R1");
        end
        wait_bc(35);
        @(negedge clk);
        #2;
        if (sb.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL scoreboard: actual=%0d expected=0 items left", sb.size());
        end
        summary();
        $finish;
    end

endmodule